// File: doc/BRIEF.md
# Programmable Region Access Guard

This block sits beside a 32-bit processor address path and judges every access against a small table of software-programmed protection regions. Each region is a naturally aligned window whose size is a power of two, from 32 bytes up to the whole 4 GB space. The window is cut into eight equal slices, and any slice can be switched off so that it drops out of the region. Each region carries its own read, write and execute-never permissions. An access brings its address, a write flag, an instruction-fetch flag and a privilege flag. In the same cycle the guard answers allow or deny and names the region that decided.

Regions are loaded one at a time through a single-cycle write port. Where enabled regions overlap, the one with the highest index decides. An address that no enabled region claims is open to privileged code and closed to unprivileged code. A global switch turns checking off, and then everything is allowed. When an access is denied, a fault record holding the address and the deciding region is registered in the next cycle, for supervisory software to act on.

Top module: `rgp_guard`

## Requirements
- R1: A write through the configuration port (cfg_we high, slot cfg_idx) replaces that slot's settings at the clock edge, and accesses from the next cycle on see the new settings.
- R2: A size code s (cfg_size) gives a region of 2^(s+1) bytes. Codes below 4 count as 4, so the smallest region is 32 bytes. Base bits below the region size are ignored, so a misaligned base falls to its aligned window.
- R3: A region is split into eight slices of 2^(s-2) bytes. The slice number is address bits [s-2+2 : s-2]. Setting bit k of cfg_sub_off removes slice k from the region, and such addresses fall through to lower regions or to the background rule.
- R4: When several enabled regions claim an address, the highest-numbered one is reported on hit_idx and its permissions decide.
- R5: Permission bits are read (cfg_rd), write (cfg_wr) and execute-never (cfg_xn). A data read needs read. A write needs write. A fetch (acc_fetch, which takes precedence over acc_write) needs read and a clear execute-never bit.
- R6: An address claimed by no enabled region is allowed when acc_priv is high and denied when it is low. hit_any is low in that case.
- R7: With guard_on low, every access is allowed, hit_any stays low, and no fault is recorded.
- R8: One cycle after a valid access that is denied, flt_valid is high, flt_addr holds the access address, flt_hit shows whether a region decided, and flt_idx holds that region. After any other cycle flt_valid is low.
- R9: Size code 31 covers the full 4 GB space, so every address falls inside that region except addresses in its disabled slices.
- R10: After reset every region is disabled and flt_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_on | input | 1 | Global check enable; low allows everything |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region slot being written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code s, region is 2^(s+1) bytes |
| cfg_sub_off | input | 8 | Slice disable mask, bit k removes slice k |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_xn | input | 1 | Execute-never |
| cfg_en | input | 1 | Region enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_allow | output | 1 | Access allowed (combinational) |
| hit_any | output | 1 | Some enabled region claims the address |
| hit_idx | output | 3 | Deciding region index |
| flt_valid | output | 1 | Registered fault indication |
| flt_addr | output | 32 | Address of the denied access |
| flt_idx | output | 3 | Region that denied it |
| flt_hit | output | 1 | Fault came from a region, not the background rule |

## Verification
The main sweep walks a 16-byte grid through the low 8 KB of the address space. It uses a table of four overlapping regions: one with a misaligned base, one with a disabled slice, and one whose size code is below the minimum. Each address is tried as a read, a write and a fetch, each with and without privilege. This separates priority, slice masking, size clamping, the three permission bits and the background rule. Directed accesses then check reprogramming of a live slot, a 4 GB region with its top slice removed, and a bypass sweep. Each access is also followed into the fault record in the next cycle, which tells a denied access apart from one that was allowed.

// File: rtl/rgp_pkg.sv
package rgp_pkg;
    localparam int RGP_AW   = 32;
    localparam int RGP_SZW  = 5;
    localparam int RGP_SUBS = 8;

    typedef struct packed {
        logic                en;
        logic [RGP_AW-1:0]   base;
        logic [RGP_SZW-1:0]  sz;
        logic [RGP_SUBS-1:0] sub_off;
        logic                rd;
        logic                wr;
        logic                xn;
    } rgp_region_t;

    typedef struct packed {
        logic              valid;
        logic [RGP_AW-1:0] addr;
        logic              hit;
    } rgp_flt_core_t;
endpackage

// File: rtl/rgp_cfg_bank.sv
module rgp_cfg_bank
    import rgp_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  rgp_region_t                   wr_word,
    output rgp_region_t [NUM_REGIONS-1:0] regs_o
);
    rgp_region_t [NUM_REGIONS-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[wr_idx] = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    // R1: a written slot holds the written word one cycle later
    assert_slot_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_idx)] == $past(wr_word));
endmodule

// File: rtl/rgp_region_match.sv
module rgp_region_match
    import rgp_pkg::*;
(
    input  rgp_region_t       region,
    input  logic [RGP_AW-1:0] addr,
    output logic              hit
);
    localparam logic [RGP_SZW-1:0] MIN_SZ = RGP_SZW'(4);

    logic [RGP_SZW-1:0] sz_eff;
    logic [RGP_AW-1:0]  keep_mask;
    logic [2:0]         slice;
    logic               in_window;

    always_comb begin
        sz_eff    = (region.sz < MIN_SZ) ? MIN_SZ : region.sz;
        // shifting by 32 clears the mask, which covers the full space
        keep_mask = {RGP_AW{1'b1}} << ({1'b0, sz_eff} + 6'd1);
        in_window = ((addr ^ region.base) & keep_mask) == '0;
        slice     = 3'(addr >> (sz_eff - RGP_SZW'(2)));
        hit       = region.en && in_window && !region.sub_off[slice];
    end
endmodule

// File: rtl/rgp_pick.sv
module rgp_pick #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REGIONS-1:0] match_vec,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match_vec[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R4: the chosen region matches and nothing above it does
    assert_highest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((match_vec >> idx_o) == NUM_REGIONS'(1)));
    assert_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (match_vec == '0));
endmodule

// File: rtl/rgp_guard.sv
module rgp_guard
    import rgp_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               guard_on,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [RGP_AW-1:0]  cfg_base,
    input  logic [RGP_SZW-1:0] cfg_size,
    input  logic [RGP_SUBS-1:0] cfg_sub_off,
    input  logic               cfg_rd,
    input  logic               cfg_wr,
    input  logic               cfg_xn,
    input  logic               cfg_en,
    input  logic               acc_valid,
    input  logic [RGP_AW-1:0]  acc_addr,
    input  logic               acc_write,
    input  logic               acc_fetch,
    input  logic               acc_priv,
    output logic               acc_allow,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               flt_valid,
    output logic [RGP_AW-1:0]  flt_addr,
    output logic [IDX_W-1:0]   flt_idx,
    output logic               flt_hit
);
    typedef struct packed {
        rgp_flt_core_t    core;
        logic [IDX_W-1:0] idx;
    } flt_state_t;

    rgp_region_t                   cfg_word;
    rgp_region_t [NUM_REGIONS-1:0] regs;
    logic [NUM_REGIONS-1:0]        match_vec, rd_v, wr_v, xn_v;
    logic                          pick_any;
    logic [IDX_W-1:0]              pick_idx;
    logic                          perm_ok;
    flt_state_t                    flt_d, flt_q;

    assign cfg_word = '{en: cfg_en, base: cfg_base, sz: cfg_size, sub_off: cfg_sub_off,
                        rd: cfg_rd, wr: cfg_wr, xn: cfg_xn};

    rgp_cfg_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_word (cfg_word),
        .regs_o  (regs)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        rgp_region_match u_match (
            .region (regs[g]),
            .addr   (acc_addr),
            .hit    (match_vec[g])
        );
        assign rd_v[g] = regs[g].rd;
        assign wr_v[g] = regs[g].wr;
        assign xn_v[g] = regs[g].xn;
    end

    rgp_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_vec (match_vec),
        .any_o     (pick_any),
        .idx_o     (pick_idx)
    );

    always_comb begin
        if (acc_fetch) begin
            perm_ok = rd_v[pick_idx] && !xn_v[pick_idx];
        end else if (acc_write) begin
            perm_ok = wr_v[pick_idx];
        end else begin
            perm_ok = rd_v[pick_idx];
        end
        acc_allow = !guard_on || (pick_any ? perm_ok : acc_priv);
        hit_any   = guard_on && pick_any;
        hit_idx   = guard_on ? pick_idx : '0;

        flt_d.core.valid = acc_valid && !acc_allow;
        flt_d.core.addr  = acc_addr;
        flt_d.core.hit   = hit_any;
        flt_d.idx        = hit_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign flt_valid = flt_q.core.valid;
    assign flt_addr  = flt_q.core.addr;
    assign flt_hit   = flt_q.core.hit;
    assign flt_idx   = flt_q.idx;

    // R8: a denied access leaves its address in the fault record
    assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=> (flt_valid && flt_addr == $past(acc_addr)));
    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_allow) |=> !flt_valid);
    // R7: bypass never produces a fault
    assert_bypass_nofault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_on && acc_valid) |=> !flt_valid);
    // R5: fetch from an execute-never region is refused
    assert_xn_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_on && pick_any && acc_fetch && xn_v[pick_idx]) |-> !acc_allow);
endmodule

// File: tb/rgp_guard_test.sv
module rgp_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guard_on = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [7:0]  cfg_sub_off = '0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_xn = 1'b0, cfg_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0;
    logic        acc_allow, hit_any, flt_valid, flt_hit;
    logic [2:0]  hit_idx, flt_idx;
    logic [31:0] flt_addr;

    int n_chk = 0;
    int n_err = 0;

    // bench copy of the region table
    logic        m_en [8];
    logic [31:0] m_base [8];
    logic [4:0]  m_sz [8];
    logic [7:0]  m_off [8];
    logic        m_rd [8], m_wr [8], m_xn [8];

    logic        pend = 1'b0, pend_flt = 1'b0, pend_hit = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [2:0]  pend_idx = '0;

    always #5 clk = ~clk;

    rgp_guard uut (
        .clk(clk), .rst_n(rst_n), .guard_on(guard_on),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_sub_off(cfg_sub_off), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_xn(cfg_xn),
        .cfg_en(cfg_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .acc_allow(acc_allow), .hit_any(hit_any), .hit_idx(hit_idx),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_idx(flt_idx), .flt_hit(flt_hit)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic w, input logic f,
                                  input logic p, output logic allow, output logic any,
                                  output logic [2:0] idx);
        logic ok;
        any = 1'b0;
        idx = 3'd0;
        for (int i = 0; i < 8; i++) begin
            longint unsigned s, span, lo;
            s    = (m_sz[i] < 5'd4) ? 4 : longint'(m_sz[i]);
            span = 64'd1 << (s + 1);
            lo   = span - 1;
            if (m_en[i] && ((longint'(a ^ m_base[i]) & ~lo & 64'hFFFF_FFFF) == 0)
                && !m_off[i][(longint'(a) / (span / 8)) % 8]) begin
                any = 1'b1;
                idx = 3'(i);
            end
        end
        if (f)      ok = m_rd[idx] && !m_xn[idx];
        else if (w) ok = m_wr[idx];
        else        ok = m_rd[idx];
        allow = any ? ok : p;
        if (!guard_on) begin
            allow = 1'b1;
            any   = 1'b0;
            idx   = 3'd0;
        end
    endfunction

    task automatic check_pend();
        if (pend) begin
            chk("R8", "flt_valid", 32'(flt_valid), 32'(pend_flt));
            if (pend_flt) begin
                chk("R8", "flt_addr", flt_addr, pend_addr);
                chk("R8", "flt_hit", 32'(flt_hit), 32'(pend_hit));
                if (pend_hit) chk("R8", "flt_idx", 32'(flt_idx), 32'(pend_idx));
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        check_pend();
        cfg_we = 1'b0;
        acc_valid = 1'b0;
        pend = 1'b1;
        pend_flt = 1'b0;
    endtask

    task automatic cfg(input int i, input logic [31:0] b, input logic [4:0] s,
                       input logic [7:0] off, input logic r, input logic w,
                       input logic x, input logic e);
        @(negedge clk);
        check_pend();
        acc_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = b; cfg_size = s; cfg_sub_off = off;
        cfg_rd = r; cfg_wr = w; cfg_xn = x; cfg_en = e;
        m_en[i] = e; m_base[i] = b; m_sz[i] = s; m_off[i] = off;
        m_rd[i] = r; m_wr[i] = w; m_xn[i] = x;
        pend = 1'b1;
        pend_flt = 1'b0;
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic f, input logic p,
                       input string tag);
        logic       ea, eany;
        logic [2:0] eidx;
        @(negedge clk);
        check_pend();
        cfg_we = 1'b0;
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
        #1;
        model(a, w, f, p, ea, eany, eidx);
        chk(tag, "acc_allow", 32'(acc_allow), 32'(ea));
        chk(tag, "hit_any", 32'(hit_any), 32'(eany));
        if (eany) chk(tag, "hit_idx", 32'(hit_idx), 32'(eidx));
        pend = 1'b1; pend_flt = !ea; pend_addr = a; pend_idx = eidx; pend_hit = eany;
    endtask

    task automatic expect_idx(input logic [31:0] a, input logic any, input logic [2:0] idx,
                              input string tag);
        acc(a, 1'b0, 1'b0, 1'b1, tag);
        chk(tag, "directed hit_any", 32'(hit_any), 32'(any));
        if (any) chk(tag, "directed hit_idx", 32'(hit_idx), 32'(idx));
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 0; m_base[i] = 0; m_sz[i] = 0; m_off[i] = 0;
            m_rd[i] = 0; m_wr[i] = 0; m_xn[i] = 0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "flt_valid after reset", 32'(flt_valid), 32'd0);
        // R10: empty table, background rule only
        acc(32'h100, 1'b0, 1'b0, 1'b0, "R10");
        chk("R10", "unpriv denied", 32'(acc_allow), 32'd0);
        acc(32'h100, 1'b1, 1'b0, 1'b1, "R10");
        chk("R10", "priv allowed", 32'(acc_allow), 32'd1);

        cfg(0, 32'h0000_0000, 5'd11, 8'h00, 1, 1, 0, 1);
        cfg(1, 32'h0000_0480, 5'd7,  8'h00, 1, 0, 1, 1);
        cfg(2, 32'h0000_0800, 5'd9,  8'h04, 1, 1, 0, 1);
        cfg(3, 32'h0000_1800, 5'd2,  8'h00, 0, 1, 1, 1);

        // R2: misaligned base and clamped size
        expect_idx(32'h0000_0400, 1'b1, 3'd1, "R2");
        expect_idx(32'h0000_1810, 1'b1, 3'd3, "R2");
        expect_idx(32'h0000_1820, 1'b0, 3'd0, "R2");
        // R3: disabled slice falls to region 0
        expect_idx(32'h0000_0910, 1'b1, 3'd0, "R3");
        expect_idx(32'h0000_0980, 1'b1, 3'd2, "R3");
        // R4: overlap goes to the higher index
        expect_idx(32'h0000_0850, 1'b1, 3'd2, "R4");
        // R5: write to read-only, fetch from execute-never
        acc(32'h0000_0410, 1'b1, 1'b0, 1'b1, "R5");
        chk("R5", "write to read-only", 32'(acc_allow), 32'd0);
        acc(32'h0000_0410, 1'b0, 1'b1, 1'b1, "R5");
        chk("R5", "fetch from xn", 32'(acc_allow), 32'd0);
        // R6: background
        acc(32'h0000_3000, 1'b0, 1'b0, 1'b0, "R6");
        chk("R6", "unpriv background", 32'(acc_allow), 32'd0);

        // sweep: every kind and privilege over the low 8 KB
        for (int a = 0; a < 32'h2000; a += 16) begin
            for (int k = 0; k < 6; k++) begin
                acc(32'(a), (k % 3) == 1, (k % 3) == 2, k >= 3, "R5");
            end
        end

        // R1: reprogram slot 1 as disabled
        cfg(1, 32'h0000_0400, 5'd7, 8'h00, 1, 0, 1, 0);
        expect_idx(32'h0000_0410, 1'b1, 3'd0, "R1");

        // R9: full-space region with its top slice removed
        cfg(7, 32'h0000_1234, 5'd31, 8'h80, 1, 0, 1, 1);
        expect_idx(32'h4000_0000, 1'b1, 3'd7, "R9");
        expect_idx(32'h0000_0850, 1'b1, 3'd7, "R9");
        expect_idx(32'hF000_0000, 1'b0, 3'd0, "R9");
        acc(32'hF000_0000, 1'b0, 1'b0, 1'b0, "R9");
        acc(32'h4000_0000, 1'b1, 1'b0, 1'b1, "R9");
        chk("R9", "write in read-only full space", 32'(acc_allow), 32'd0);
        for (int a = 0; a < 16; a++) begin
            acc(32'(a) << 28, a[0], a[1], a[2], "R9");
        end

        // R7: bypass
        guard_on = 1'b0;
        for (int a = 0; a < 64; a++) begin
            acc((32'(a) << 26) | 32'h10, a[0], a[1], 1'b0, "R7");
            chk("R7", "bypass allows", 32'(acc_allow), 32'd1);
        end
        idle();
        guard_on = 1'b1;
        acc(32'h4000_0000, 1'b1, 1'b0, 1'b0, "R7");
        idle();
        idle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule